// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This controller sits beside a small 8-bit processor core and turns a set of request events into one vectored interrupt. There are sixteen sources, numbered 0 to 15.

- Thirteen sources are on-chip peripheral pulses.
- Two are external pins. Each pin has its own programmable trigger edge.
- Source 0 is a software break request, raised by the core when it executes its break instruction.

Every source has a sticky pending flag. A pending source is offered to the core only when both of these are 1:

- its bit in one of two byte-wide enable registers;
- the global interrupt enable.

When several sources are live, the one with the highest number wins.

The core accepts the offered vector by pulsing an acknowledge. That pulse has three effects:

- it clears the winner's pending flag;
- it clears the global enable;
- when the winner is source 0, it sets a break flag.

The break flag lets software tell a break apart from a table call through entry 0, because the two share vector 0. Software can nest handlers by setting the global enable again inside a handler. A return from interrupt also sets the global enable again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req`, `gie` and `brk_flag` are 0, both enable bytes are 0 and both pin edge modes are "off". A pending source therefore raises no request even once `gie` is 1.
- R2: When more than one source is live, `irq_vec` names the highest-numbered live source. A source is live when it is pending, enabled and `gie` is 1. Source 15 has the highest priority and source 0 the lowest.
- R3: `irq_req` is 1 only while some source is live. A source that is pending but masked (by its enable bit or by `gie` = 0) keeps its pending flag and is offered as soon as it is unmasked.
- R4: An accepted acknowledge (`irq_ack` = 1 while `irq_req` = 1) clears the pending flag of the offered source and sets `gie` to 0 at the same clock edge.
- R5: A trigger event for a source that is already pending, or that arrives in the same cycle as that source's accepted acknowledge, leaves the flag set.
- R6: `gie_set` or `reti_exec` sets `gie` to 1. A pending, enabled source then preempts the running handler, which allows nesting.
- R7: Source 0 is set by `brk_req`. Accepting vector 0 sets `brk_flag` to 1, and `tcall0_exec` clears it. If both happen in one cycle, the set wins.
- R8: Each external pin passes through two synchronizing flops before edge detection. An edge on the pin sets its pending flag at the third rising clock edge after the pin changes. The pin's 2-bit mode selects the trigger:
  - 00: falling edge;
  - 01: rising edge;
  - 10: both edges;
  - 11: off.
- R9: Register writes (`wr_en` = 1) are selected by `wr_sel`:
  - 0 writes the low enable byte, which holds sources 7..0;
  - 1 writes the high enable byte, which holds sources 15..8;
  - 2 writes the pin modes: bits [1:0] for external pin 1 (source 14) and bits [3:2] for external pin 2 (source 13).

  A high byte of 0x40 with a low byte of 0x00 enables only external pin 1.
- R10: The precedence on `gie` is: an accepted acknowledge first, then `gie_clr`, then `gie_set` or `reti_exec`. `gie_clr` alone sets `gie` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_evt | input | 13 | Peripheral event pulses. Bits 11..0 map to sources 12..1; bit 12 maps to source 15 |
| xpin1 | input | 1 | External pin 1 (source 14), asynchronous |
| xpin2 | input | 1 | External pin 2 (source 13), asynchronous |
| brk_req | input | 1 | Break instruction executed (source 0 event) |
| tcall0_exec | input | 1 | Table call through entry 0 executed; clears the break flag |
| reti_exec | input | 1 | Return from interrupt executed; sets `gie` |
| gie_set | input | 1 | Enable-interrupts instruction |
| gie_clr | input | 1 | Disable-interrupts instruction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low enable byte, 1 high enable byte, 2 pin modes |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_req | output | 1 | A live source is offered |
| irq_vec | output | 4 | Number of the offered source |
| gie | output | 1 | Global interrupt enable |
| brk_flag | output | 1 | Break flag for the status word |

## Verification
The assertions check the following on every cycle:
- the offered vector is pending and enabled, and no higher-numbered source is live;
- the grant is one-hot;
- an acknowledge always clears `gie` and the winner's flag;
- an acknowledge of vector 0 always sets the break flag;
- a return from interrupt restores `gie`;
- a pin in the "off" mode never produces an event.

Only the bench's scenarios can show the remaining properties:
- the exact three-edge latency of the pin synchronizer and each edge mode;
- the sticky flag when an event collides with its own acknowledge;
- preemption of a handler once `gie` is set again;
- the 0x40/0x00 enable pattern, which exposes only pin 1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BYTE_W = 8;
  localparam int NSRC   = 2 * BYTE_W;
  localparam int VW     = $clog2(NSRC);
  localparam int NPER   = NSRC - 3;
  localparam int X1_IDX = NSRC - 2;
  localparam int X2_IDX = NSRC - 3;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_t;

  // Highest set bit wins; returns 0 for an empty vector.
  function automatic logic [VW-1:0] top_index(input logic [NSRC-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) r = VW'(i);
    return r;
  endfunction

  // Precedence: accept > clear > set.
  function automatic logic gie_next(input logic cur, input logic take,
                                    input logic clr, input logic set);
    if (take)      return 1'b0;
    else if (clr)  return 1'b0;
    else if (set)  return 1'b1;
    else           return cur;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_t mode,
  output logic       evt
);
  logic s1, s2, prev;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;

  always_comb begin
    unique case (mode)
      EDGE_FALL: evt = fall;
      EDGE_RISE: evt = rise;
      EDGE_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  AST_EDGE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF) |-> !evt);  // R8
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] live,
  output logic            any,
  output logic [VW-1:0]   vec,
  output logic [NSRC-1:0] grant
);
  assign any   = |live;
  assign vec   = top_index(live);
  assign grant = any ? (NSRC'(1) << vec) : '0;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPER-1:0] per_evt,
  input  logic            xpin1,
  input  logic            xpin2,
  input  logic            brk_req,
  input  logic            tcall0_exec,
  input  logic            reti_exec,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [7:0]      wr_data,
  input  logic            irq_ack,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec,
  output logic            gie,
  output logic            brk_flag
);
  logic [BYTE_W-1:0] en_lo, en_hi;
  logic [3:0]        pin_cfg;
  logic [NSRC-1:0]   pend, en_all, live, grant, evt_vec, ack_mask;
  logic [1:0]        pin_in, pin_evt;
  logic              take;

  assign pin_in = {xpin2, xpin1};

  for (genvar p = 0; p < 2; p++) begin : g_pin
    irqc_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pin_in[p]),
      .mode (edge_mode_t'(pin_cfg[2*p +: 2])),
      .evt  (pin_evt[p])
    );
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (s == 0)               begin : g_brk assign evt_vec[s] = brk_req;          end
    else if (s == X1_IDX)     begin : g_x1  assign evt_vec[s] = pin_evt[0];       end
    else if (s == X2_IDX)     begin : g_x2  assign evt_vec[s] = pin_evt[1];       end
    else if (s == NSRC - 1)   begin : g_top assign evt_vec[s] = per_evt[NPER-1];  end
    else                      begin : g_per assign evt_vec[s] = per_evt[s-1];     end
  end

  assign en_all = {en_hi, en_lo};
  assign live   = pend & en_all & {NSRC{gie}};

  irqc_pick u_pick (
    .live (live),
    .any  (irq_req),
    .vec  (irq_vec),
    .grant(grant)
  );

  assign take     = irq_ack & irq_req;
  assign ack_mask = take ? grant : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_lo    <= '0;
      en_hi    <= '0;
      pin_cfg  <= {EDGE_OFF, EDGE_OFF};
      pend     <= '0;
      gie      <= 1'b0;
      brk_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0:    en_lo   <= wr_data;
          2'd1:    en_hi   <= wr_data;
          2'd2:    pin_cfg <= wr_data[3:0];
          default: ;
        endcase
      end
      pend <= (pend & ~ack_mask) | evt_vec;
      gie  <= gie_next(gie, take, gie_clr, gie_set | reti_exec);
      if (take && irq_vec == '0) brk_flag <= 1'b1;
      else if (tcall0_exec)      brk_flag <= 1'b0;
    end
  end

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);  // R3
  AST_REQ_IS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_vec] && en_all[irq_vec]));  // R3
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R2
  AST_NO_HIGHER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((live >> irq_vec) >> 1) == '0);  // R2
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);  // R4
  AST_TAKE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !evt_vec[irq_vec]) |=> !pend[$past(irq_vec)]);  // R4
  AST_BRK_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_vec == '0) |=> brk_flag);  // R7
  AST_RETI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_exec && !take && !gie_clr) |=> gie);  // R6
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] per_evt = '0;
  logic        xpin1 = 1'b0, xpin2 = 1'b0;
  logic        brk_req = 1'b0, tcall0_exec = 1'b0, reti_exec = 1'b0;
  logic        gie_set = 1'b0, gie_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic        gie, brk_flag;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .per_evt(per_evt), .xpin1(xpin1), .xpin2(xpin2),
    .brk_req(brk_req), .tcall0_exec(tcall0_exec), .reti_exec(reti_exec),
    .gie_set(gie_set), .gie_clr(gie_clr), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
    .gie(gie), .brk_flag(brk_flag)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  bit m_pend[16];
  bit m_en[16];
  int m_mode[2];
  bit m_gie, m_brk;
  bit hist1[$], hist2[$];

  function automatic int m_winner();
    for (int i = 15; i >= 0; i--)
      if (m_pend[i] && m_en[i] && m_gie) return i;
    return -1;
  endfunction

  function automatic bit pin_fire(int mode, bit nw, bit od);
    case (mode)
      0: return od && !nw;
      1: return nw && !od;
      2: return nw != od;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[i]) begin m_pend[i] = 0; m_en[i] = 0; end
      m_mode[0] = 3; m_mode[1] = 3;
      m_gie = 0; m_brk = 0;
      hist1 = '{0, 0, 0, 0};
      hist2 = '{0, 0, 0, 0};
    end else begin
      bit ev[16];
      int w;
      bit tk;
      w  = m_winner();
      tk = irq_ack && (w >= 0);
      hist1.push_front(xpin1); void'(hist1.pop_back());
      hist2.push_front(xpin2); void'(hist2.pop_back());
      foreach (ev[i]) ev[i] = 0;
      for (int i = 1; i <= 12; i++) ev[i] = per_evt[i-1];
      ev[15] = per_evt[12];
      ev[0]  = brk_req;
      ev[14] = pin_fire(m_mode[0], hist1[2], hist1[3]);
      ev[13] = pin_fire(m_mode[1], hist2[2], hist2[3]);
      if (tk && w == 0) m_brk = 1;
      else if (tcall0_exec) m_brk = 0;
      if (tk) m_gie = 0;
      else if (gie_clr) m_gie = 0;
      else if (gie_set || reti_exec) m_gie = 1;
      for (int i = 0; i < 16; i++) begin
        if (tk && i == w) m_pend[i] = 0;
        if (ev[i]) m_pend[i] = 1;
      end
      if (wr_en) begin
        if (wr_sel == 0) for (int i = 0; i < 8; i++) m_en[i] = wr_data[i];
        if (wr_sel == 1) for (int i = 0; i < 8; i++) m_en[i+8] = wr_data[i];
        if (wr_sel == 2) begin
          m_mode[0] = wr_data[1:0];
          m_mode[1] = wr_data[3:2];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int w;
      w = m_winner();
      vectors++;
      if (irq_req !== (w >= 0)) begin
        fails++; $display("FAIL R3 irq_req act=%0d exp=%0d", irq_req, w >= 0);
      end
      if (w >= 0 && irq_vec !== 4'(w)) begin
        fails++; $display("FAIL R2 irq_vec act=%0d exp=%0d", irq_vec, w);
      end
      if (gie !== m_gie) begin
        fails++; $display("FAIL R6 gie act=%0d exp=%0d", gie, m_gie);
      end
      if (brk_flag !== m_brk) begin
        fails++; $display("FAIL R7 brk_flag act=%0d exp=%0d", brk_flag, m_brk);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(data);
    step();
    wr_en = 0;
  endtask

  task automatic pulse_set();
    gie_set = 1; step(); gie_set = 0;
  endtask

  task automatic ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 irq_req", irq_req, 0);
    chk("R1 gie", gie, 0);
    chk("R1 brk_flag", brk_flag, 0);

    gie_set = 1; per_evt[4] = 1; step(); gie_set = 0; per_evt[4] = 0;
    step();
    chk("R1 masked by reset enables", irq_req, 0);
    wr(0, 8'h20);
    chk("R9 low byte enables src5", irq_req, 1);
    chk("R9 vec src5", irq_vec, 5);
    ack();
    chk("R4 gie dropped", gie, 0);
    pulse_set();
    chk("R4 flag cleared", irq_req, 0);

    wr(1, 8'hFF); wr(0, 8'hFF);
    per_evt[2] = 1; per_evt[8] = 1; per_evt[11] = 1; step(); per_evt = '0;
    chk("R2 highest wins", irq_vec, 12);
    ack();
    per_evt[12] = 1; step(); per_evt = '0;
    chk("R3 gie masks src15", irq_req, 0);
    pulse_set();
    chk("R6 nesting preempt", irq_vec, 15);
    ack();
    reti_exec = 1; step(); reti_exec = 0;
    chk("R6 reti restores gie", gie, 1);
    chk("R2 next in order", irq_vec, 9);
    irq_ack = 1; per_evt[8] = 1; step(); irq_ack = 0; per_evt = '0;
    pulse_set();
    chk("R5 collision keeps flag", irq_vec, 9);
    ack(); pulse_set();
    chk("R2 low one remains", irq_vec, 3);
    gie_clr = 1; step(); gie_clr = 0;
    chk("R10 gie_clr", gie, 0);
    pulse_set();
    irq_ack = 1; gie_set = 1; step(); irq_ack = 0; gie_set = 0;
    chk("R10 accept beats set", gie, 0);

    brk_req = 1; per_evt[0] = 1; step(); brk_req = 0; per_evt = '0;
    pulse_set();
    chk("R7 break lowest", irq_vec, 1);
    ack(); pulse_set();
    chk("R7 break vector", irq_vec, 0);
    ack();
    chk("R7 brk_flag set", brk_flag, 1);
    tcall0_exec = 1; step(); tcall0_exec = 0;
    chk("R7 tcall0 clears", brk_flag, 0);

    wr(1, 8'h40); wr(0, 8'h00); pulse_set();
    per_evt[11] = 1; brk_req = 1; step(); per_evt = '0; brk_req = 0;
    chk("R9 0x40 masks others", irq_req, 0);
    xpin1 = 1; repeat (4) step();
    chk("R8 off mode", irq_req, 0);
    xpin1 = 0; wr(2, 8'h01); repeat (4) step();
    xpin1 = 1; step(); step();
    chk("R8 not before third edge", irq_req, 0);
    step();
    chk("R8 rising latency", irq_vec, 14);
    chk("R8 rising req", irq_req, 1);
    ack(); pulse_set();
    wr(2, 8'h00);
    xpin1 = 0; repeat (3) step();
    chk("R8 falling", irq_req, 1);
    ack(); pulse_set();
    wr(2, 8'h02);
    xpin1 = 1; repeat (3) step();
    chk("R8 both rise", irq_req, 1);
    ack(); pulse_set();
    xpin1 = 0; repeat (3) step();
    chk("R8 both fall", irq_req, 1);
    ack();
    repeat (3) step();

    done = 1;
    summary();
    $finish;
  end
endmodule